// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register reads and writes on a two-wire PHY management bus of the classic 5-bit-address kind. It derives the MDC clock from the system clock. It drives or releases the shared MDIO line through three separate signals: a data output, an output enable and a data input. The pad buffer that joins them sits outside the block.

A transaction starts with a one-cycle strobe. The strobe carries:
- a read/write flag,
- a 5-bit PHY address,
- a 5-bit register address,
- 16 bits of write data.

The block latches the command and sends the whole frame. On a read it collects the reply. It then returns 16-bit read data, a one-cycle done pulse and an error flag.

If the PHY does not pull the read turnaround bit low, the block clocks a fixed number of further cycles to drain whatever the PHY might still be sending. It then reports all-ones data with the error flag set.

Top module: `mdio_master`

## Requirements
- R1: While reset is low, mdc, mdioOe, busy, done and err are 0 and rdData is 0.
- R2: A frame opens with 32 MDC cycles carrying 1, then the start pair 0,1, then the opcode pair: 1,0 for a read and 0,1 for a write. The opcode is decoded by the PHY.
- R3: After the opcode the block sends the 5-bit PHY address, then the 5-bit register address, each most significant bit first.
- R4: A write sends the turnaround pair 1,0 and the 16 data bits MSB first, all with mdioOe high. It then releases the line for one idle MDC cycle, so a write spans 65 MDC cycles.
- R5: A read drops mdioOe after the register address. It then samples one turnaround bit and 16 data bits MSB first, plus one idle cycle: 64 MDC cycles in all. When the turnaround bit is 0, rdData returns the 16 sampled bits.
- R6: If the sampled read turnaround bit is 1, the block clocks 32 more released MDC cycles (79 in all) and discards them. It then sets rdData to 0xFFFF and raises err.
- R7: Every MDC low phase lasts HALF_CYC system clocks. A high phase lasts HALF_CYC clocks for bits the block sends and RDHI_CYC clocks for bits it receives. mdioOut changes only while mdc is low.
- R8: A received bit is the value of mdioIn in the last system clock of its MDC high phase, taken as MDC is lowered.
- R9: The command is latched when start is seen while idle. busy is high from the next cycle until the transaction ends. done is a one-cycle pulse in the first cycle busy is low again. start and the command inputs have no effect while busy.
- R10: err changes only by being set in R6 and by being cleared when the next command is accepted. mdioOe is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmdRead | input | 1 | 1 = read, 0 = write |
| phyAddr | input | 5 | PHY address |
| regAddr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Result of the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Read turnaround failure |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven on MDIO |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Value seen on MDIO |

## Verification
The bench sweeps every PHY address across writes and reads with varied register addresses and data, alongside a small PHY model. It records each MDC cycle's bit, enable and phase lengths.

The frame checks catch a design that gets the opcode, the bit order or the release point wrong, since its recorded bits or enable would differ. A sampler placed on the rising MDC edge would read the PHY's previous bit, and the returned data would come back shifted. A design with the wrong cycle count or phase length shows up as a different MDC total or timing.

Turnaround failures are checked for the 79-cycle flush, 0xFFFF and err. A design that gave up early or kept the stale data would fail there. The next command must clear err on acceptance. A start pulsed mid-frame must leave the frame and the idle bus untouched, which catches a design that restarts or queues a second transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FLUSH_BITS = 32;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_RD     = 2'b10;
  localparam logic [1:0] OP_WR     = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_TA,
    ST_RX,
    ST_FLUSH,
    ST_TAIL
  } mdioState_t;

  typedef struct packed {
    logic load;
    logic shiftTx;
    logic shiftRx;
    logic capRd;
    logic flagErr;
  } dpCtl_t;
endpackage

// File: rtl/mdio_slot_timer.sv
module mdio_slot_timer #(
  parameter int HALF_CYC = 50,
  parameter int RDHI_CYC = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic longHigh,
  output logic mdc,
  output logic slotEnd
);
  localparam int MAXC = (HALF_CYC > RDHI_CYC) ? HALF_CYC : RDHI_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [TW-1:0] tick;
  logic          highPh;
  logic [TW-1:0] lim;

  assign lim = (highPh && longHigh) ? TW'(RDHI_CYC - 1) : TW'(HALF_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick   <= '0;
      highPh <= 1'b0;
    end else if (!run) begin
      tick   <= '0;
      highPh <= 1'b0;
    end else if (tick == lim) begin
      tick   <= '0;
      highPh <= ~highPh;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign mdc     = highPh;
  assign slotEnd = run && highPh && (tick == lim);

  // R10
  idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   cmdRead,
  input  logic   mdi,
  input  logic   slotEnd,
  output logic   busy,
  output logic   longHigh,
  output logic   oe,
  output logic   done,
  output dpCtl_t ctl
);
  localparam int CW = $clog2(FRAME_BITS);

  mdioState_t    state;
  logic          rdMode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastTx;

  assign lastTx = rdMode ? CW'(HDR_BITS - 1) : CW'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rdMode <= 1'b0;
      cnt    <= '0;
      oe     <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_TX;
          rdMode <= cmdRead;
          cnt    <= '0;
          oe     <= 1'b1;
        end
        ST_TX: if (slotEnd) begin
          if (cnt == lastTx) begin
            cnt   <= '0;
            oe    <= 1'b0;
            state <= rdMode ? ST_TA : ST_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TA: if (slotEnd) begin
          cnt   <= '0;
          state <= mdi ? ST_FLUSH : ST_RX;
        end
        ST_RX: if (slotEnd) begin
          if (cnt == CW'(DATA_W - 1)) begin
            cnt   <= '0;
            state <= ST_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FLUSH: if (slotEnd) begin
          if (cnt == CW'(FLUSH_BITS - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: if (slotEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && start;
    ctl.shiftTx = (state == ST_TX) && slotEnd;
    ctl.shiftRx = (state == ST_RX) && slotEnd;
    ctl.capRd   = (state == ST_TAIL) && slotEnd && rdMode;
    ctl.flagErr = (state == ST_FLUSH) && slotEnd && (cnt == CW'(FLUSH_BITS - 1));
  end

  assign busy     = (state != ST_IDLE);
  assign longHigh = (state == ST_TA) || (state == ST_RX) ||
                    (state == ST_FLUSH) || (state == ST_TAIL);

  // R10
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !oe);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && start) |=> (state == ST_TX) && oe);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdi,
  output logic              mdo,
  output logic [DATA_W-1:0] rdData,
  output logic              err
);
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
    end else if (ctl.load) begin
      txShift <= {{PRE_BITS{1'b1}}, START_PAT, (cmdRead ? OP_RD : OP_WR),
                  phyAddr, regAddr, TA_WR, wrData};
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign mdo = txShift[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (ctl.shiftRx) begin
      rxShift <= {rxShift[DATA_W-2:0], mdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
      err    <= 1'b0;
    end else begin
      if (ctl.load) err <= 1'b0;
      if (ctl.capRd) rdData <= rxShift;
      if (ctl.flagErr) begin
        rdData <= {DATA_W{1'b1}};
        err    <= 1'b1;
      end
    end
  end

  // R6
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rdData == {DATA_W{1'b1}}));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 50,
  parameter int RDHI_CYC = 70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cmdRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCtl_t ctl;
  logic   slotEnd;
  logic   longHigh;

  mdio_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmdRead  (cmdRead),
    .mdi      (mdioIn),
    .slotEnd  (slotEnd),
    .busy     (busy),
    .longHigh (longHigh),
    .oe       (mdioOe),
    .done     (done),
    .ctl      (ctl)
  );

  mdio_slot_timer #(
    .HALF_CYC (HALF_CYC),
    .RDHI_CYC (RDHI_CYC)
  ) uTimer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .longHigh (longHigh),
    .mdc      (mdc),
    .slotEnd  (slotEnd)
  );

  mdio_dp uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .cmdRead (cmdRead),
    .phyAddr (phyAddr),
    .regAddr (regAddr),
    .wrData  (wrData),
    .mdi     (mdioIn),
    .mdo     (mdioOut),
    .rdData  (rdData),
    .err     (err)
  );

  // R7
  mdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start));
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int HALF = 2;
  localparam int RDHI = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmdRead = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy, done, err, mdc, mdioOut, mdioOe;
  logic        mdioIn;
  logic        phyDrive = 1'b1;
  logic        phyTa = 1'b0;
  logic [15:0] phyData = '0;

  assign mdioIn = mdioOe ? mdioOut : phyDrive;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF), .RDHI_CYC(RDHI)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmdRead(cmdRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int errors = 0;
  int checks = 0;

  // bus monitor and PHY model
  logic bitVal [0:99];
  logic bitOe  [0:99];
  int   lowLen [0:99];
  int   highLen[0:99];
  int   idx = 0;
  int   runLen = 0;
  logic prevMdc = 1'b0;
  logic prevBusy = 1'b0;

  always @(negedge clk) begin
    if (busy && !prevBusy) begin
      idx    = 0;
      runLen = 0;
    end
    if (mdc !== prevMdc) begin
      if (mdc) begin
        if (idx < 100) begin
          bitVal[idx] = mdioOut;
          bitOe[idx]  = mdioOe;
          lowLen[idx] = runLen;
        end
        if (idx == 46) phyDrive = phyTa;
        else if (idx >= 47 && idx <= 62) phyDrive = phyData[62-idx];
        else phyDrive = 1'b1;
        idx++;
      end else if (idx >= 1 && idx <= 100) begin
        highLen[idx-1] = runLen;
      end
      runLen = 1;
    end else begin
      runLen++;
    end
    prevMdc  = mdc;
    prevBusy = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input bit ta,
                        input logic [15:0] pd, input bit inj);
    int cyc;
    int expCnt;
    int txCnt;
    int bad;
    logic [13:0] hdr;
    logic [17:0] wtail;
    phyTa   = ta;
    phyData = pd;
    cmdRead = rd; phyAddr = pa; regAddr = ra; wrData = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cmdRead = ~rd; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd;
    chk(busy === 1'b1, "R9", "busy after accept", int'(busy), 1);
    chk(err === 1'b0, "R10", "err cleared on accept", int'(err), 0);
    cyc = 0;
    while (done !== 1'b1) begin
      if (inj && cyc == 40) begin
        start = 1'b1; cmdRead = ~rd; phyAddr = pa + 5'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(busy === 1'b0, "R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", int'(done), 0);

    txCnt  = rd ? 46 : 64;
    expCnt = !rd ? 65 : (ta ? 79 : 64);
    chk(idx == expCnt, rd ? (ta ? "R6" : "R5") : "R4", "MDC cycle count", idx, expCnt);

    bad = 0;
    for (int k = 0; k < 32; k++) if (bitVal[k] !== 1'b1 || bitOe[k] !== 1'b1) bad++;
    chk(bad == 0, "R2", "preamble bits", bad, 0);

    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    bad = 0;
    for (int k = 0; k < 4; k++) if (bitVal[32+k] !== hdr[13-k] || bitOe[32+k] !== 1'b1) bad++;
    chk(bad == 0, "R2", "start and opcode bits", bad, 0);
    bad = 0;
    for (int k = 4; k < 14; k++) if (bitVal[32+k] !== hdr[13-k] || bitOe[32+k] !== 1'b1) bad++;
    chk(bad == 0, "R3", "address bits", bad, 0);

    if (!rd) begin
      wtail = {2'b10, wd};
      bad = 0;
      for (int k = 0; k < 18; k++) if (bitVal[46+k] !== wtail[17-k] || bitOe[46+k] !== 1'b1) bad++;
      chk(bad == 0, "R4", "turnaround and data bits", bad, 0);
      chk(bitOe[64] === 1'b0, "R4", "idle cycle released", int'(bitOe[64]), 0);
    end else begin
      bad = 0;
      for (int k = 46; k < expCnt; k++) if (bitOe[k] !== 1'b0) bad++;
      chk(bad == 0, "R5", "line released for reply", bad, 0);
      if (ta) begin
        chk(rdData === 16'hFFFF, "R6", "flush data", int'(rdData), 16'hFFFF);
        chk(err === 1'b1, "R6", "err flag", int'(err), 1);
      end else begin
        chk(rdData === pd, "R5", "read data (R8 sampling)", int'(rdData), int'(pd));
        chk(err === 1'b0, "R5", "err flag clear", int'(err), 0);
      end
    end

    bad = 0;
    for (int k = 0; k < expCnt; k++) begin
      if (k > 0 && lowLen[k] != HALF) bad++;
      if (highLen[k] != ((k < txCnt) ? HALF : RDHI)) bad++;
    end
    chk(bad == 0, "R7", "phase lengths", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] wd;
    repeat (4) @(negedge clk);
    chk(mdc === 1'b0 && mdioOe === 1'b0, "R1", "mdc/oe in reset", int'({mdc, mdioOe}), 0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "busy/done/err in reset",
        int'({busy, done, err}), 0);
    chk(rdData === 16'h0, "R1", "rdData in reset", int'(rdData), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 32; i++) begin
      wd = 16'(i * 16'h0843) ^ 16'h5A3C;
      runTxn(1'b0, 5'(i), 5'((i * 7) % 32), wd, 1'b0, 16'h0, 1'b0);
      runTxn(1'b1, 5'(i), 5'((i * 7) % 32), 16'h0, 1'b0, ~wd ^ 16'(i), 1'b0);
    end

    for (int i = 0; i < 3; i++) begin
      runTxn(1'b1, 5'(i + 9), 5'(i), 16'h0, 1'b1, 16'h1234 + 16'(i), 1'b0);
      repeat (5) @(negedge clk);
      chk(err === 1'b1, "R10", "err holds while idle", int'(err), 1);
      chk(mdioOe === 1'b0, "R10", "oe low while idle", int'(mdioOe), 0);
      runTxn(1'b0, 5'(i + 1), 5'(i + 20), 16'hC001 + 16'(i), 1'b0, 16'h0, 1'b0);
    end

    runTxn(1'b0, 5'd17, 5'd4, 16'hBEEF, 1'b0, 16'h0, 1'b1);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0, "R9", "start while busy ignored", int'(busy), 0);
    chk(idx == 65, "R9", "no extra frame after ignored start", idx, 65);
    chk(mdioOe === 1'b0, "R10", "oe low while idle", int'(mdioOe), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule